// File: doc/BRIEF.md
# Multi-Function Pin Output Selector

This block decides how one dual-purpose device pin behaves. A 3-bit function code chooses between leaving the pin as an input and driving it from one of several internal sources: a temperature-good flag, an auto-mute-active flag, a divided copy of the PLL clock, a PLL-lock flag, or a fixed 0 or 1. A polarity bit inverts whatever is driven. A 2-bit ratio code picks a divide of 1, 2, 3 or 4 for the clock source. When the function code leaves the pin as an input, a separate mode level decides its input role. With the mode in 3-wire control the pin is the serial chip-select input. Otherwise it is a jack-detect input.

Setting writes arrive as parallel fields with a single write strobe. They are held in reset-initialised registers. The block runs on the PLL clock. Its reset is asynchronous and active low, and its release is synchronised by two flops inside the block. The status sources and the mode level reach the pin outputs through combinational logic only.

Top module: `gpsel_out_sel`

## Requirements
- R1: After reset, the function code is 000, the polarity bit is 0 and the ratio code is 00. With the mode low this leaves `pin_oe`=0, `pin_do`=0, `in_jack`=1 and `in_cs`=0.
- R2: When `cfg_we` is high at a rising clock edge, all three setting fields are loaded at that edge. The outputs reflect the new settings within that same following cycle. When `cfg_we` is low the settings hold.
- R3: While `mode_3w` is 1, the outputs are `pin_oe`=0, `in_cs`=1 and `in_jack`=0, whatever the function code is.
- R4: With function code 000 and `mode_3w`=0, the outputs are `pin_oe`=0, `in_jack`=1 and `in_cs`=0.
- R5: Function code 001 is reserved. With `mode_3w`=0 it gives `pin_oe`=0 with both role flags at 0.
- R6: Function codes 010, 011 and 101 drive `pin_oe`=1. `pin_do` then equals `temp_ok`, `amute_act` or `pll_lock` respectively, XOR the polarity bit, in the same cycle as the source.
- R7: Function codes 110 and 111 drive `pin_oe`=1 with `pin_do` equal to the polarity bit XOR 0 or 1 respectively.
- R8: Whenever `pin_oe` is 0, `pin_do` is 0.
- R9: Function code 100 drives the clock divided by N = ratio code + 1. For N=1, `pin_do` follows `clk`. For N of 2 to 4, `pin_do` is steady within each cycle and repeats every N cycles, high for floor(N/2) cycles of each period. The output is XOR the polarity bit.
- R10: A new ratio code takes effect only when the current divide period wraps. The old period always finishes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL clock; also the clock divider source |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_3w | input | 1 | 1 = 3-wire control mode (pin is chip-select) |
| cfg_we | input | 1 | Setting write strobe |
| cfg_fsel | input | 3 | Function code to write |
| cfg_inv | input | 1 | Polarity bit to write (1 = invert) |
| cfg_div | input | 2 | Ratio code to write (N = code + 1) |
| temp_ok | input | 1 | Temperature-good flag source |
| amute_act | input | 1 | Auto-mute-active flag source |
| pll_lock | input | 1 | PLL-lock flag source |
| pin_oe | output | 1 | Pin output enable |
| pin_do | output | 1 | Pin output data |
| in_cs | output | 1 | Pin acts as chip-select input |
| in_jack | output | 1 | Pin acts as jack-detect input |

## Verification
Source and mode changes are applied a quarter period after an edge, and the outputs are sampled one time unit later, since they pass through no register. A setting write is driven with the strobe before an edge. Its effect is checked a quarter period after that edge. For the clock source, every sample is taken in both the high and the low half of each cycle. The divide-by-1 case is judged against the clock level. The ratio-change case locks on an observed rising output, which marks the start of a period, and then checks the next eight cycles against the old and new periods in turn.

// File: rtl/gpsel_pkg.sv
package gpsel_pkg;

  // Function codes of the pin; the numeric values are decoded by the mux
  typedef enum logic [2:0] {
    FN_INPUT  = 3'b000,
    FN_RSVD   = 3'b001,
    FN_TEMP   = 3'b010,
    FN_AMUTE  = 3'b011,
    FN_PLLCLK = 3'b100,
    FN_LOCK   = 3'b101,
    FN_LOW    = 3'b110,
    FN_HIGH   = 3'b111
  } fn_sel_e;

  localparam int unsigned FN_W = 3;

endpackage

// File: rtl/gpsel_rst_sync.sv
module gpsel_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpsel_cfg_reg.sv
module gpsel_cfg_reg
  import gpsel_pkg::*;
#(
  parameter int unsigned DIV_W    = 2,
  parameter logic [2:0]  RST_FSEL = 3'b000,
  parameter logic        RST_INV  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [FN_W-1:0]  fsel_in,
  input  logic             inv_in,
  input  logic [DIV_W-1:0] div_in,
  output fn_sel_e          fsel_q,
  output logic             inv_q,
  output logic [DIV_W-1:0] div_q
);

  fn_sel_e          fsel_d;
  logic             inv_d;
  logic [DIV_W-1:0] div_d;

  // Next-state: load on the write strobe, otherwise hold
  always_comb begin
    fsel_d = fsel_q;
    inv_d  = inv_q;
    div_d  = div_q;
    if (we) begin
      fsel_d = fn_sel_e'(fsel_in);
      inv_d  = inv_in;
      div_d  = div_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q <= fn_sel_e'(RST_FSEL);
      inv_q  <= RST_INV;
      div_q  <= '0;
    end else begin
      fsel_q <= fsel_d;
      inv_q  <= inv_d;
      div_q  <= div_d;
    end
  end

endmodule

// File: rtl/gpsel_clk_div.sv
module gpsel_clk_div #(
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio_code,
  output logic             div_o,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W-1:0] ratio_o
);

  localparam int unsigned HW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q,   cnt_d;
  logic [DIV_W-1:0] ratio_q, ratio_d;
  logic             wrap;
  logic [HW-1:0]    period;
  logic [HW-1:0]    half;
  logic             phase;

  // Period is ratio+1 cycles; the counter runs 0..ratio
  always_comb begin
    period  = {1'b0, ratio_q} + HW'(1);
    half    = period >> 1;
    wrap    = (cnt_q == ratio_q);
    cnt_d   = wrap ? '0 : cnt_q + DIV_W'(1);
    // A new ratio is only adopted as the period ends
    ratio_d = wrap ? ratio_code : ratio_q;
    phase   = ({1'b0, cnt_q} < half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
    end
  end

  // Ratio 0 means divide by 1: the clock itself is passed on
  assign div_o   = (ratio_q == '0) ? clk : phase;
  assign cnt_o   = cnt_q;
  assign ratio_o = ratio_q;

endmodule

// File: rtl/gpsel_src_mux.sv
module gpsel_src_mux
  import gpsel_pkg::*;
(
  input  fn_sel_e fsel,
  input  logic    inv,
  input  logic    mode_3w,
  input  logic    temp_ok,
  input  logic    amute_act,
  input  logic    pll_lock,
  input  logic    pll_div,
  output logic    pin_oe,
  output logic    pin_do,
  output logic    in_cs,
  output logic    in_jack
);

  logic src_val;
  logic src_drv;

  always_comb begin
    src_val = 1'b0;
    src_drv = 1'b0;
    unique case (fsel)
      FN_INPUT:  begin src_val = 1'b0;      src_drv = 1'b0; end
      FN_RSVD:   begin src_val = 1'b0;      src_drv = 1'b0; end
      FN_TEMP:   begin src_val = temp_ok;   src_drv = 1'b1; end
      FN_AMUTE:  begin src_val = amute_act; src_drv = 1'b1; end
      FN_PLLCLK: begin src_val = pll_div;   src_drv = 1'b1; end
      FN_LOCK:   begin src_val = pll_lock;  src_drv = 1'b1; end
      FN_LOW:    begin src_val = 1'b0;      src_drv = 1'b1; end
      FN_HIGH:   begin src_val = 1'b1;      src_drv = 1'b1; end
    endcase
  end

  // The 3-wire mode overrides every function code
  always_comb begin
    pin_oe  = src_drv & ~mode_3w;
    pin_do  = pin_oe & (src_val ^ inv);
    in_cs   = mode_3w;
    in_jack = ~mode_3w & (fsel == FN_INPUT);
  end

endmodule

// File: rtl/gpsel_out_sel.sv
module gpsel_out_sel
  import gpsel_pkg::*;
#(
  parameter int unsigned DIV_W    = 2,
  parameter int unsigned SYNC_N   = 2,
  parameter logic [2:0]  RST_FSEL = 3'b000,
  parameter logic        RST_INV  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_3w,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_fsel,
  input  logic             cfg_inv,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             temp_ok,
  input  logic             amute_act,
  input  logic             pll_lock,
  output logic             pin_oe,
  output logic             pin_do,
  output logic             in_cs,
  output logic             in_jack
);

  logic             rst_sync_n;
  fn_sel_e          fsel_q;
  logic             inv_q;
  logic [DIV_W-1:0] div_q;
  logic             pll_div;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_ratio;

  gpsel_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpsel_cfg_reg #(
    .DIV_W    (DIV_W),
    .RST_FSEL (RST_FSEL),
    .RST_INV  (RST_INV)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (cfg_we),
    .fsel_in (cfg_fsel),
    .inv_in  (cfg_inv),
    .div_in  (cfg_div),
    .fsel_q  (fsel_q),
    .inv_q   (inv_q),
    .div_q   (div_q)
  );

  gpsel_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ratio_code (div_q),
    .div_o      (pll_div),
    .cnt_o      (div_cnt),
    .ratio_o    (div_ratio)
  );

  gpsel_src_mux u_mux (
    .fsel      (fsel_q),
    .inv       (inv_q),
    .mode_3w   (mode_3w),
    .temp_ok   (temp_ok),
    .amute_act (amute_act),
    .pll_lock  (pll_lock),
    .pll_div   (pll_div),
    .pin_oe    (pin_oe),
    .pin_do    (pin_do),
    .in_cs     (in_cs),
    .in_jack   (in_jack)
  );

endmodule

// File: rtl/gpsel_out_sel_chk.sv
module gpsel_out_sel_chk #(
  parameter int unsigned DIV_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_3w,
  input logic             cfg_we,
  input logic [2:0]       cfg_fsel,
  input logic [2:0]       fsel_q,
  input logic             inv_q,
  input logic             pin_oe,
  input logic             pin_do,
  input logic             in_cs,
  input logic             in_jack,
  input logic [DIV_W-1:0] div_cnt,
  input logic [DIV_W-1:0] div_ratio
);

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_we)) |-> (fsel_q == $past(cfg_fsel))); // R2

  AST_MODE_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_3w |-> (!pin_oe && in_cs && !in_jack)); // R3

  AST_RSVD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_3w && fsel_q == 3'b001) |-> (!pin_oe && !in_cs && !in_jack)); // R5

  AST_CONST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && fsel_q == 3'b110) |-> (pin_do == inv_q)); // R7

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_do); // R8

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= div_ratio); // R9

  AST_RATIO_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(div_ratio)) |-> (div_cnt == '0)); // R10

endmodule

bind gpsel_out_sel gpsel_out_sel_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .mode_3w   (mode_3w),
  .cfg_we    (cfg_we),
  .cfg_fsel  (cfg_fsel),
  .fsel_q    (fsel_q),
  .inv_q     (inv_q),
  .pin_oe    (pin_oe),
  .pin_do    (pin_do),
  .in_cs     (in_cs),
  .in_jack   (in_jack),
  .div_cnt   (div_cnt),
  .div_ratio (div_ratio)
);

// File: tb/gpsel_out_sel_tb.sv
module gpsel_out_sel_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = CLK_PERIOD / 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_3w;
  logic       cfg_we;
  logic [2:0] cfg_fsel;
  logic       cfg_inv;
  logic [1:0] cfg_div;
  logic       temp_ok, amute_act, pll_lock;
  logic       pin_oe, pin_do, in_cs, in_jack;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpsel_out_sel dut_i (
    .clk(clk), .rst_n(rst_n), .mode_3w(mode_3w), .cfg_we(cfg_we),
    .cfg_fsel(cfg_fsel), .cfg_inv(cfg_inv), .cfg_div(cfg_div),
    .temp_ok(temp_ok), .amute_act(amute_act), .pll_lock(pll_lock),
    .pin_oe(pin_oe), .pin_do(pin_do), .in_cs(in_cs), .in_jack(in_jack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Move to a quarter period after the next rising edge
  task automatic step();
    @(posedge clk);
    #(Q);
  endtask

  task automatic write_cfg(input logic [2:0] f, input logic inv, input logic [1:0] d);
    cfg_fsel = f; cfg_inv = inv; cfg_div = d; cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  function automatic string req_of(input int f, input int m);
    if (m != 0) return "R3";
    case (f)
      0: return "R4";
      1: return "R5";
      6, 7: return "R7";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_3w = 1'b0; cfg_we = 1'b0; cfg_fsel = 3'b111;
    cfg_inv = 1'b1; cfg_div = 2'b11; temp_ok = 1'b0; amute_act = 1'b0; pll_lock = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1: reset defaults seen at the pins
    chk("R1 oe/do/cs/jack", {28'd0, pin_oe, pin_do, in_cs, in_jack}, 32'b0001);

    // R2: strobe low leaves the settings alone
    cfg_fsel = 3'b111; cfg_inv = 1'b0; cfg_we = 1'b0;
    step();
    chk("R2 no write holds", {31'd0, pin_oe}, 32'd0);
    write_cfg(3'b111, 1'b0, 2'b00);
    chk("R2 write visible", {30'd0, pin_oe, pin_do}, 32'b11);

    // Static sweep over every non-clock function, polarity, mode and source mix
    for (int f = 0; f < 8; f++) begin
      if (f == 4) continue;
      for (int inv = 0; inv < 2; inv++) begin
        write_cfg(3'(f), 1'(inv), 2'b00);
        for (int m = 0; m < 2; m++) begin
          for (int s = 0; s < 8; s++) begin
            logic eoe, esrc, edo, ecs, ejk;
            mode_3w = 1'(m); temp_ok = s[0]; amute_act = s[1]; pll_lock = s[2];
            #1;
            eoe  = (m == 0) && (f >= 2);
            esrc = (f == 2) ? s[0] : (f == 3) ? s[1] : (f == 5) ? s[2] : (f == 7);
            edo  = eoe & (esrc ^ 1'(inv));   // R8 when not driving
            ecs  = 1'(m);
            ejk  = (m == 0) && (f == 0);
            chk(req_of(f, m), {28'd0, pin_oe, pin_do, in_cs, in_jack},
                {28'd0, eoe, edo, ecs, ejk});
          end
        end
      end
    end
    mode_3w = 1'b0; temp_ok = 1'b0; amute_act = 1'b0; pll_lock = 1'b0;

    // R9: clock source, every ratio and polarity
    for (int d = 0; d < 4; d++) begin
      for (int inv = 0; inv < 2; inv++) begin
        logic hs[12];
        logic ls[12];
        int   highs, nper, bad;
        write_cfg(3'b100, 1'(inv), 2'(d));
        repeat (8) step();
        for (int i = 0; i < 12; i++) begin
          hs[i] = pin_do ^ 1'(inv);
          #(CLK_PERIOD/2);
          ls[i] = pin_do ^ 1'(inv);
          step();
        end
        nper = d + 1; highs = 0; bad = 0;
        for (int i = 0; i < 12; i++) begin
          if (nper == 1) begin
            if (hs[i] !== 1'b1 || ls[i] !== 1'b0) bad++;
          end else begin
            if (hs[i] !== ls[i]) bad++;
            if (i + nper < 12 && hs[i] !== hs[i+nper]) bad++;
            if (hs[i] === 1'b1) highs++;
          end
        end
        chk("R9 shape", bad, 0);
        if (nper > 1) chk("R9 high count", highs, (12 / nper) * (nper / 2));
      end
    end

    // R10: ratio change waits for the end of the running period
    begin
      logic prev, got[8];
      int   tries;
      logic [7:0] seen;
      write_cfg(3'b100, 1'b0, 2'b11);
      repeat (8) step();
      prev = pin_do; tries = 0;
      step();
      while (!(prev == 1'b0 && pin_do == 1'b1) && tries < 20) begin
        prev = pin_do; step(); tries++;
      end
      got[0] = pin_do;
      cfg_fsel = 3'b100; cfg_inv = 1'b0; cfg_div = 2'b01; cfg_we = 1'b1;
      step();
      cfg_we = 1'b0;
      got[1] = pin_do;
      for (int i = 2; i < 8; i++) begin
        step();
        got[i] = pin_do;
      end
      for (int i = 0; i < 8; i++) seen[7-i] = got[i];
      chk("R10 period sequence", {24'd0, seen}, {24'd0, 8'b11001010});
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule